// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block is the sending half of a start-stop serial link. A host hands it one character at a time over a valid/ready write port. Each character lands in a one-entry holding register, then moves into a separate shift register and leaves on the serial line, least significant bit first. Each frame starts with a low start bit and ends with high stop bits. Between them come seven or eight data bits, an optional even or odd parity bit and an optional address-marker bit. The marker bit lets one sender address several listeners on a shared line.

An external divider supplies `baud_tick`, a single-cycle enable that marks every bit boundary. The block keeps no sense of rate of its own. The format inputs are sampled when a character enters the shift register, so a frame in flight is never changed by them.

Two levels serve as interrupt or DMA requests. `in_ready` says the holding register can take another character. `tx_end` says the line has gone quiet with nothing left to send. The write port applies back-pressure in the usual way: a character is taken in any clock where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_data` and `in_mark` are not sampled. The host may hold `in_valid` high as long as it likes.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `in_ready` is 1 and `tx_end` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 from that edge on. Writes offered while `in_ready` is 0 are ignored: the character already held is the one sent.
- R3: A held character moves to the shift register on the first `baud_tick` at which the shifter is idle or is finishing its last bit. `in_ready` returns to 1 at that same edge. Before that tick, `txd` stays 1.
- R4: A frame is a 0 start bit, then the data bits LSB first, then parity (if on), then the marker bit (if on), then the stop bits. Each bit is held on `txd` from one `baud_tick` edge to the next.
- R5: With `cfg_len8`=0 only `in_data[6:0]` is sent and `in_data[7]` has no effect on `txd`. With `cfg_len8`=1 all eight bits are sent.
- R6: With `cfg_par_en`=1 a parity bit follows the data bits. It is computed over the sent data bits only. With `cfg_par_odd`=0 the count of ones in data plus parity is even; with `cfg_par_odd`=1 it is odd.
- R7: With `cfg_mark_en`=1 one bit equal to the `in_mark` value written with the character follows the parity position.
- R8: With `cfg_stop2`=0 the frame ends with one stop bit of value 1; with `cfg_stop2`=1 it ends with two.
- R9: A character written while the previous frame is shifting starts its start bit at the tick that ends the previous frame's last stop bit, with no idle bit time between the frames.
- R10: `tx_end` is 1 exactly when the shifter is idle and the holding register is empty. It falls on the edge that accepts a write and rises on the tick that ends the last stop bit when nothing is held.
- R11: The format inputs are captured when a character enters the shift register. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle bit-boundary enable |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_mark_en | input | 1 | Address-marker bit present |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | Holding register empty (data-empty request) |
| in_data | input | DATA_W | Character to send |
| in_mark | input | 1 | Marker bit value for this character |
| txd | output | 1 | Serial line, idle high |
| tx_end | output | 1 | Line idle and nothing held (transmission-end request) |

## Verification
If the bit counter is off by one, the next frame shows an extra or missing bit within a few ticks. It may also start late, which shows on `txd` at the tick where the stop bit should end. If the holding flag sticks or clears too early, `in_ready` disagrees with the bench one clock after the write or the load. It can also surface as a repeated or lost character on the line. A wrong parity sense or data length corrupts a single bit at a known position, so the first faulty frame pins it down. `tx_end` is compared on every write and at every frame end, so a bad idle decision shows within one tick.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef struct packed {
    logic len8;
    logic stop2;
    logic par_en;
    logic par_odd;
    logic mark_en;
  } tx_fmt_t;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic              take,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_mark
);
  logic accept;

  assign in_ready = !full;
  assign accept   = in_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
      hold_mark <= 1'b0;
    end else if (accept) begin
      full      <= 1'b1;
      hold_data <= in_data;
      hold_mark <= in_mark;
    end else if (take) begin
      full      <= 1'b0;
    end
  end

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R3
  AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_ready); // R3
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(hold_data) && $stable(hold_mark))); // R2
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 1 + DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  tx_fmt_t            fmt,
  input  logic [DATA_W-1:0]  data,
  input  logic               mark,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  int   dlen;
  int   pos;
  logic par;

  always_comb begin
    dlen  = fmt.len8 ? DATA_W : DATA_W - 1;
    frame = '1;
    frame[0] = 1'b0;
    par   = fmt.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dlen) begin
        frame[1 + i] = data[i];
        par          = par ^ data[i];
      end
    end
    pos = 1 + dlen;
    if (fmt.par_en) begin
      frame[pos] = par;
      pos        = pos + 1;
    end
    if (fmt.mark_en) begin
      frame[pos] = mark;
      pos        = pos + 1;
    end
    nbits = CNT_W'(pos + (fmt.stop2 ? 2 : 1));
  end
endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine #(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               have_data,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  output logic               take,
  output logic               busy,
  output logic               txd
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               last;

  assign last = busy && (left_q == CNT_W'(1));
  assign take = tick && have_data && (!busy || last);
  assign txd  = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (tick) begin
      if (take) begin
        sh_q   <= frame;
        left_q <= nbits;
        busy   <= 1'b1;
      end else if (busy) begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - CNT_W'(1);
        if (last) busy <= 1'b0;
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd); // R4
  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd)); // R4
  AST_LAST_IS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (last && tick) |-> txd); // R8
endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_len8,
  input  logic              cfg_stop2,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mark_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  output logic              txd,
  output logic              tx_end
);
  localparam int FRAME_W = 1 + DATA_W + 1 + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  tx_fmt_t            fmt;
  logic               full;
  logic               take;
  logic               busy;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_mark;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign fmt = '{len8: cfg_len8, stop2: cfg_stop2, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, mark_en: cfg_mark_en};

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_mark(in_mark), .take(take), .in_ready(in_ready), .full(full),
    .hold_data(hold_data), .hold_mark(hold_mark)
  );

  tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
    .fmt(fmt), .data(hold_data), .mark(hold_mark), .frame(frame), .nbits(nbits)
  );

  tx_shift_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .have_data(full),
    .frame(frame), .nbits(nbits), .take(take), .busy(busy), .txd(txd)
  );

  assign tx_end = !busy && !full;

  AST_END_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> txd); // R10
  AST_END_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> in_ready); // R10
  AST_NO_LOAD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !in_ready) |=> !in_ready); // R3
endmodule

// File: tb/serial_tx_framer_test.sv
`timescale 1ns/1ps
module serial_tx_framer_test;
  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic cfg_len8 = 1, cfg_stop2 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mark_en = 0;
  logic in_valid = 0, in_mark = 0;
  logic [7:0] in_data = 0;
  logic in_ready, txd, tx_end;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len8(cfg_len8),
    .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_mark_en(cfg_mark_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .txd(txd), .tx_end(tx_end)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick1();
    @(negedge clk) baud_tick = 1;
    @(negedge clk) baud_tick = 0;
  endtask

  task automatic wr(input logic [7:0] d, input logic m);
    @(negedge clk) begin in_valid = 1; in_data = d; in_mark = m; end
    @(negedge clk) in_valid = 0;
  endtask

  // Expected frame, bit 0 first on the line.
  function automatic int exp_frame(input logic [7:0] d, input logic m,
                                   input logic l8, s2, pe, po, me,
                                   output int n, output int dl, output int ppos, output int mpos);
    int v, f, pos, par, ns;
    dl  = l8 ? 8 : 7;
    v   = int'(d) & ((1 << dl) - 1);
    f   = v << 1;
    pos = 1 + dl;
    par = ($countones(v) % 2) ^ (po ? 1 : 0);
    ppos = -1; mpos = -1;
    if (pe) begin f |= par << pos; ppos = pos; pos++; end
    if (me) begin f |= (m ? 1 : 0) << pos; mpos = pos; pos++; end
    ns = s2 ? 2 : 1;
    f |= ((1 << ns) - 1) << pos;
    n = pos + ns;
    return f;
  endfunction

  function automatic string tag_of(input int k, input int dl, input int ppos, input int mpos, input logic l8);
    if (k == 0) return "R4";
    if (k <= dl) return l8 ? "R4" : "R5";
    if (k == ppos) return "R6";
    if (k == mpos) return "R7";
    return "R8";
  endfunction

  // Check the remaining bits k=1..n-1 of a frame whose start bit is on the line.
  task automatic follow(input int f, input int n, input int dl, input int ppos, input int mpos, input logic l8);
    for (int k = 1; k < n; k++) begin
      tick1();
      chk(txd, f[k], tag_of(k, dl, ppos, mpos, l8));
      chk(tx_end, 1'b0, "R10");
    end
  endtask

  task automatic one_frame(input logic [7:0] d, input logic m);
    int f, n, dl, pp, mp;
    f = exp_frame(d, m, cfg_len8, cfg_stop2, cfg_par_en, cfg_par_odd, cfg_mark_en, n, dl, pp, mp);
    chk(tx_end, 1'b1, "R10");
    wr(d, m);
    chk(in_ready, 1'b0, "R2");
    chk(tx_end, 1'b0, "R10");
    repeat (2) @(negedge clk);
    chk(txd, 1'b1, "R3");
    tick1();
    chk(txd, 1'b0, "R4");
    chk(in_ready, 1'b1, "R3");
    follow(f, n, dl, pp, mp, cfg_len8);
    tick1();
    chk(txd, 1'b1, "R8");
    chk(tx_end, 1'b1, "R10");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h7F};
    int fa, fb, na, nb, dla, dlb, ppa, ppb, mpa, mpb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd, 1'b1, "R1");
    chk(in_ready, 1'b1, "R1");
    chk(tx_end, 1'b1, "R1");

    // Sweep every format with several characters.
    for (int c = 0; c < 24; c++) begin
      cfg_len8    = c[0];
      cfg_stop2   = c[1];
      cfg_mark_en = c[2];
      cfg_par_en  = (c / 8) != 0;
      cfg_par_odd = (c / 8) == 2;
      for (int p = 0; p < 7; p++) one_frame(pats[p], p[0]);
    end

    // R9 back-to-back plus R2 ignored write while full.
    cfg_len8 = 1; cfg_stop2 = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_mark_en = 0;
    fa = exp_frame(8'h3C, 0, 1, 0, 1, 0, 0, na, dla, ppa, mpa);
    fb = exp_frame(8'hC3, 0, 1, 0, 1, 0, 0, nb, dlb, ppb, mpb);
    wr(8'h3C, 0);
    tick1();
    chk(txd, 1'b0, "R4");
    wr(8'hC3, 0);
    chk(in_ready, 1'b0, "R2");
    wr(8'hFF, 1);
    chk(in_ready, 1'b0, "R2");
    follow(fa, na, dla, ppa, mpa, 1);
    tick1();
    chk(txd, 1'b0, "R9");
    chk(in_ready, 1'b1, "R9");
    chk(tx_end, 1'b0, "R10");
    follow(fb, nb, dlb, ppb, mpb, 1);
    tick1();
    chk(txd, 1'b1, "R8");
    chk(tx_end, 1'b1, "R10");

    // R11 format change mid-frame.
    cfg_len8 = 1; cfg_stop2 = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_mark_en = 0;
    fa = exp_frame(8'h96, 1, 1, 0, 0, 0, 0, na, dla, ppa, mpa);
    wr(8'h96, 1);
    tick1();
    chk(txd, 1'b0, "R11");
    cfg_len8 = 0; cfg_stop2 = 1; cfg_par_en = 1; cfg_par_odd = 1; cfg_mark_en = 1;
    for (int k = 1; k < na; k++) begin
      tick1();
      chk(txd, fa[k], "R11");
    end
    tick1();
    chk(txd, 1'b1, "R11");
    chk(tx_end, 1'b1, "R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule